// File: doc/BRIEF.md
# Shared Bus Ownership Handshake Controller

This block sits beside one master on a shared external bus and decides when that master may hold the bus. The bus has a single active-low busy line. Each master drives that line through its own open-drain style driver, and an external pull-up holds it high when nobody drives it. An external arbiter gives each master a grant. The local bus interface gives a request and a transfer-done pulse. From these the controller drives the busy line through a value output and an enable output. It also tells the local side whether it currently owns the bus.

Ownership is taken only after the grant is held and the busy line has been seen free. When the local transfers end, the owner may stay on the bus (parking) for as long as its grant holds, whatever the request shows. Later transfers then start with no new arbitration. When the grant is lost, the controller first lets any transfer in flight finish. It then drives the line high for exactly one clock and then floats it. All inputs are sampled, and all outputs change, on the rising edge of one system clock.

Top module: `bus_own_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy_n_oe` and `owns_bus` are 0.
- R2: A request together with a grant moves an idle controller to a waiting state and does not drive the line. It takes ownership (`owns_bus`=1) one cycle after a clock edge at which it was waiting, the grant was high and `busy_n_in` was sampled 1 (line free). While `busy_n_in` reads 0 it keeps waiting.
- R3: While owning, the controller drives the line low (`busy_n_oe`=1, `busy_n_out`=0). `owns_bus` is 1 exactly when `busy_n_oe`=1 and `busy_n_out`=0.
- R4: When `xfer_done` is seen while owning with the grant high and `req` low, the controller parks. It keeps driving low and keeps `owns_bus`=1 for as long as the grant stays high, whatever `req` does.
- R5: A parked owner that sees `req` with the grant still high resumes active ownership in the next cycle, with no release and no wait. An active owner that sees `xfer_done` with `req` and the grant high stays active.
- R6: If a parked owner sees the grant low, or an active owner sees `xfer_done` with the grant low, it drives `busy_n_out`=1 with `busy_n_oe`=1 and `owns_bus`=0 for exactly one cycle. It then tri-states (`busy_n_oe`=0) and is idle.
- R7: An active owner whose grant is withdrawn keeps ownership until `xfer_done` arrives. A transfer is never cut short.
- R8: If the grant drops while the controller is waiting, it returns to idle without ever enabling the driver.
- R9: While it neither owns the bus nor is in its one release cycle, `busy_n_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req | input | 1 | Local bus interface wants the bus |
| grant | input | 1 | Grant from the external arbiter |
| busy_n_in | input | 1 | Sampled shared busy line (0 = bus busy, 1 = free) |
| xfer_done | input | 1 | Current local transfer completes this cycle |
| busy_n_out | output | 1 | Value driven onto the busy line when enabled |
| busy_n_oe | output | 1 | Driver enable for the busy line (0 = floating) |
| owns_bus | output | 1 | Local master currently owns the bus |

## Verification
All outputs are decoded from one state register. Every result is therefore due exactly one clock edge after the inputs that cause it were sampled. The bench changes inputs on the falling edge and steps its reference model once for that input set. It then compares all three outputs on the next falling edge, after the single rising edge that should update them. The corner sequences are:
- a long wait on a busy line;
- a grant withdrawn during the wait;
- a grant lost during an active transfer that is held for several cycles before done;
- parking with `req` toggling;
- the single release cycle.

Each of these is checked cycle by cycle against the model, never against a settled value.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT    = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_PARKED  = 3'd3,
    ST_RELEASE = 3'd4
  } own_state_e;

endpackage

// File: rtl/bus_own_next.sv
module bus_own_next
  import bus_own_pkg::*;
(
  input  own_state_e state_i,
  input  logic       req_i,
  input  logic       grant_i,
  input  logic       line_free_i,
  input  logic       done_i,
  output own_state_e state_o
);

  always_comb begin
    state_o = state_i;
    unique case (state_i)
      ST_IDLE: begin
        if (req_i && grant_i) state_o = ST_WAIT;
      end
      ST_WAIT: begin
        if (!grant_i)         state_o = ST_IDLE;
        else if (line_free_i) state_o = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        // a transfer in flight is always allowed to finish
        if (done_i) begin
          if (!grant_i)    state_o = ST_RELEASE;
          else if (!req_i) state_o = ST_PARKED;
        end
      end
      ST_PARKED: begin
        if (!grant_i)   state_o = ST_RELEASE;
        else if (req_i) state_o = ST_ACTIVE;
      end
      ST_RELEASE: state_o = ST_IDLE;
      default:    state_o = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/bus_own_outdec.sv
module bus_own_outdec
  import bus_own_pkg::*;
(
  input  own_state_e state_i,
  output logic       drv_val_o,
  output logic       drv_en_o,
  output logic       own_o
);

  always_comb begin
    drv_val_o = 1'b0;
    drv_en_o  = 1'b0;
    own_o     = 1'b0;
    unique case (state_i)
      ST_ACTIVE, ST_PARKED: begin
        drv_en_o = 1'b1;
        own_o    = 1'b1;
      end
      ST_RELEASE: begin
        drv_val_o = 1'b1;
        drv_en_o  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic grant,
  input  logic busy_n_in,
  input  logic xfer_done,
  output logic busy_n_out,
  output logic busy_n_oe,
  output logic owns_bus
);

  own_state_e state_q;
  own_state_e state_d;
  logic       state_en;

  bus_own_next u_next (
    .state_i     (state_q),
    .req_i       (req),
    .grant_i     (grant),
    .line_free_i (busy_n_in),
    .done_i      (xfer_done),
    .state_o     (state_d)
  );

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  bus_own_outdec u_dec (
    .state_i   (state_q),
    .drv_val_o (busy_n_out),
    .drv_en_o  (busy_n_oe),
    .own_o     (owns_bus)
  );

  AST_TAKE_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owns_bus) |-> $past(grant && busy_n_in)) else $error("take without free line"); // R2
  AST_OWN_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    owns_bus |-> (busy_n_oe && !busy_n_out)) else $error("owner not driving low"); // R3
  AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (owns_bus && grant) |=> owns_bus) else $error("dropped with grant held"); // R4
  AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n_oe && busy_n_out) |=> !busy_n_oe) else $error("release longer than one cycle"); // R6
  AST_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && !xfer_done) |=> owns_bus) else $error("transfer cut short"); // R7
  AST_WITHDRAW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !grant) |=> !busy_n_oe) else $error("drove after grant withdrawn"); // R8
  AST_TRISTATE_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!owns_bus && !busy_n_out) |-> !busy_n_oe) else $error("driver on while not owner"); // R9

endmodule

// File: tb/bus_own_ctrl_bench.sv
`timescale 1ns/1ps
module bus_own_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic req, grant, busy_n_in, xfer_done;
  logic busy_n_out, busy_n_oe, owns_bus;

  int vectors = 0;
  int miscompares = 0;
  int model_st = 0;   // 0 idle, 1 wait, 2 active, 3 parked, 4 release
  bit finished = 0;

  always #4 clk = ~clk;

  bus_own_ctrl u_bus_own_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
    .busy_n_in(busy_n_in), .xfer_done(xfer_done),
    .busy_n_out(busy_n_out), .busy_n_oe(busy_n_oe), .owns_bus(owns_bus)
  );

  function automatic int model_next(int s, bit r, bit g, bit f, bit d);
    if (s == 0) return (r && g) ? 1 : 0;
    if (s == 1) return !g ? 0 : (f ? 2 : 1);
    if (s == 2) return !d ? 2 : (!g ? 4 : (r ? 2 : 3));
    if (s == 3) return !g ? 4 : (r ? 2 : 3);
    return 0;
  endfunction

  task automatic compare(string tag);
    bit e_oe, e_out, e_own;
    e_oe  = (model_st >= 2);
    e_out = (model_st == 4);
    e_own = (model_st == 2) || (model_st == 3);
    vectors++;
    if (busy_n_oe !== e_oe || busy_n_out !== e_out || owns_bus !== e_own) begin
      miscompares++;
      $display("FAIL %s: oe/out/own actual %b%b%b expected %b%b%b (model state %0d)",
               tag, busy_n_oe, busy_n_out, owns_bus, e_oe, e_out, e_own, model_st);
    end
  endtask

  // inputs set at negedge, one rising edge, outputs compared at next negedge
  task automatic step(bit r, bit g, bit f, bit d, string tag);
    req = r; grant = g; busy_n_in = f; xfer_done = d;
    model_st = model_next(model_st, r, g, f, d);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b1; grant = 1'b1; busy_n_in = 1'b1; xfer_done = 1'b0;
    repeat (2) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    model_st = 0;
    step(0, 0, 1, 0, "R1 after reset");
    step(0, 1, 1, 0, "R9 idle no req");
    // R2: wait on a busy line, then take when free
    step(1, 1, 0, 0, "R2 enter wait");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R2 line busy keep waiting");
    step(1, 1, 1, 0, "R2 take on free line");
    step(1, 1, 0, 0, "R3 owner drives low");
    // R4: park, req toggling while grant held
    step(0, 1, 0, 1, "R4 park on done");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R4 parked idle");
    // R5: resume without rearbitration
    step(1, 1, 0, 0, "R5 resume from park");
    step(1, 1, 0, 1, "R5 done with req stays active");
    step(0, 1, 0, 1, "R4 park again");
    // R6: lose grant while parked
    step(0, 0, 0, 0, "R6 release drive high");
    step(0, 0, 1, 0, "R6 tristate after release");
    step(0, 0, 1, 0, "R9 idle after release");
    // R8: grant withdrawn during wait
    step(1, 1, 0, 0, "R8 enter wait");
    step(1, 0, 0, 0, "R8 withdraw to idle");
    step(1, 0, 1, 0, "R8 no drive");
    // R7: grant lost mid transfer
    step(1, 1, 0, 0, "R2 wait again");
    step(1, 1, 1, 0, "R2 take again");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R7 hold until done");
    step(1, 0, 0, 1, "R7 R6 release after done");
    step(0, 0, 1, 0, "R6 tristate");
    // R1: reset while owning
    step(1, 1, 1, 0, "R2 wait");
    step(1, 1, 1, 0, "R2 own");
    rst_n = 1'b0;
    model_st = 0;
    #1;
    compare("R1 async reset while owning");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 1, 0, "R1 idle after reset");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule